// File: doc/BRIEF.md
# USB Full-Speed Device Link State Monitor

This block follows the bus-level condition of a Full-Speed USB device port and reports which link state the device is in. Its inputs are the VBUS sense level, an interface-enable control, a two-bit decoded line condition (single-ended zero, idle J, or any other value) and a one-cycle start-of-frame strobe from the protocol engine. It runs on the 48 MHz USB clock.

It measures how long SE0 and idle J last, and it measures the gap between start-of-frame strobes. From these it moves between five states: Disconnected, Powered, Powered Suspend, Active and Suspended. Suspend has two states. One is entered before the device has seen a bus reset and the other after it, so a resume returns the device to the right place. Each link event is a one-cycle pulse that an interrupt controller can latch: disconnect, bus reset, suspend, resume and host lost. The state code is registered.

All inputs and outputs are plain level or pulse signals. Nothing streams through the block, so no valid/ready handshake applies and there is no back-pressure. The time limits are parameters. Their defaults are 144 cycles for reset (3 us), 144000 cycles for suspend (3 ms) and 196608 cycles for host lost (4.096 ms).

Top module: `usb_link_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `state_o` is 0 (Disconnected) and all five event outputs are 0.
- R2: The state code is 0 Disconnected, 1 Powered, 2 Powered Suspend, 3 Active and 4 Suspended. When `vbus_sense_i` or `enable_i` is low on a rising edge, the state becomes 0 after that edge. `ev_disconnect_o` pulses for that one cycle only if the state was not already 0.
- R3: In Disconnected, the state becomes 1 after the first edge at which `vbus_sense_i` and `enable_i` are both high.
- R4: When SE0 is sampled on RESET_CYCLES consecutive edges while powered, `ev_reset_o` pulses after the last of those edges and the state becomes 3. Any other line value restarts the count. A continuous SE0 produces only one pulse.
- R5: When J is sampled on SUSPEND_CYCLES consecutive edges while powered, `ev_suspend_o` pulses once. The state moves from 1 to 2 or from 3 to 4. Any non-J value restarts the count.
- R6: In state 2 or 4, the first edge that samples a non-J line raises `ev_resume_o`. The state returns from 2 to 1, or from 4 to 3.
- R7: In state 3, when `sof_i` is low on HOST_LOST_CYCLES consecutive edges, `ev_host_lost_o` pulses once. A high `sof_i` restarts the count, and so does leaving state 3.
- R8: The line code is 2'b00 SE0, 2'b01 J, 2'b10 K and 2'b11 other. Codes 2'b10 and 2'b11 both count as non-idle and non-SE0.
- R9: Every event output is high for single cycles only. At most one of the disconnect, reset, suspend and resume events is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz USB clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Interface enable; low holds the monitor in Disconnected |
| vbus_sense_i | input | 1 | VBUS present |
| line_i | input | 2 | Decoded line condition (R8 encoding) |
| sof_i | input | 1 | One-cycle start-of-frame strobe |
| state_o | output | 3 | Registered link state code |
| ev_disconnect_o | output | 1 | Disconnect event pulse |
| ev_reset_o | output | 1 | Bus reset event pulse |
| ev_suspend_o | output | 1 | Suspend event pulse |
| ev_resume_o | output | 1 | Resume event pulse |
| ev_host_lost_o | output | 1 | Host lost event pulse |

## Verification
The bound checker tests these properties on every cycle:
- The state code is always legal.
- Each event agrees with the state transition that caused it: reset lands in Active, suspend lands in a suspend state, resume leaves one, and host lost comes only from Active.
- A low VBUS or enable forces Disconnected on the next edge.
- A Powered Suspend never jumps directly to Active.
- The mutually exclusive events never coincide.

Some behaviours are about elapsed time, so only the bench scenarios can show them:
- The exact cycle on which a timed event fires.
- That an interrupted SE0 or J run restarts its count.
- That a held condition produces only one pulse.
- That regular start-of-frame strobes keep the host-lost event from firing.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;

  typedef enum logic [2:0] {
    LS_DISCONNECTED = 3'd0,
    LS_POWERED      = 3'd1,
    LS_PWR_SUSPEND  = 3'd2,
    LS_ACTIVE       = 3'd3,
    LS_SUSPENDED    = 3'd4
  } link_state_e;

  typedef enum logic [1:0] {
    LINE_SE0   = 2'b00,
    LINE_J     = 2'b01,
    LINE_K     = 2'b10,
    LINE_OTHER = 2'b11
  } line_cond_e;

endpackage

// File: rtl/usb_lm_line_decode.sv
module usb_lm_line_decode
  import usb_lm_pkg::*;
(
  input  logic [1:0] line_i,
  output logic       is_se0_o,
  output logic       is_j_o
);

  always_comb begin
    is_se0_o = 1'b0;
    is_j_o   = 1'b0;
    unique case (line_cond_e'(line_i))
      LINE_SE0: is_se0_o = 1'b1;
      LINE_J:   is_j_o   = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/usb_lm_hold_timer.sv
// Counts consecutive cycles a condition is held. Fires once, on the cycle
// that completes LIMIT consecutive samples, then saturates until the
// condition drops.
module usb_lm_hold_timer #(
  parameter int unsigned LIMIT = 144
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic hit_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!cond_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = cond_i && (cnt_q == CNT_LAST);

endmodule

// File: rtl/usb_lm_fsm.sv
module usb_lm_fsm
  import usb_lm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       powered_i,
  input  logic       line_j_i,
  input  logic       reset_hit_i,
  input  logic       idle_hit_i,
  input  logic       nosof_hit_i,
  output logic [2:0] state_o,
  output logic       ev_disconnect_o,
  output logic       ev_reset_o,
  output logic       ev_suspend_o,
  output logic       ev_resume_o,
  output logic       ev_host_lost_o
);

  link_state_e st_q, st_d;
  logic e_dis, e_rst, e_sus, e_res, e_hl;

  always_comb begin
    st_d  = st_q;
    e_dis = 1'b0;
    e_rst = 1'b0;
    e_sus = 1'b0;
    e_res = 1'b0;
    e_hl  = 1'b0;
    if (!powered_i) begin
      st_d  = LS_DISCONNECTED;
      e_dis = (st_q != LS_DISCONNECTED);
    end else begin
      unique case (st_q)
        LS_DISCONNECTED: st_d = LS_POWERED;
        LS_POWERED: begin
          if (reset_hit_i) begin
            st_d  = LS_ACTIVE;
            e_rst = 1'b1;
          end else if (idle_hit_i) begin
            st_d  = LS_PWR_SUSPEND;
            e_sus = 1'b1;
          end
        end
        LS_PWR_SUSPEND: begin
          if (!line_j_i) begin
            st_d  = LS_POWERED;
            e_res = 1'b1;
          end
        end
        LS_ACTIVE: begin
          e_hl = nosof_hit_i;
          if (reset_hit_i) begin
            e_rst = 1'b1;
          end else if (idle_hit_i) begin
            st_d  = LS_SUSPENDED;
            e_sus = 1'b1;
          end
        end
        LS_SUSPENDED: begin
          if (!line_j_i) begin
            st_d  = LS_ACTIVE;
            e_res = 1'b1;
          end
        end
        default: st_d = LS_DISCONNECTED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= LS_DISCONNECTED;
      ev_disconnect_o <= 1'b0;
      ev_reset_o      <= 1'b0;
      ev_suspend_o    <= 1'b0;
      ev_resume_o     <= 1'b0;
      ev_host_lost_o  <= 1'b0;
    end else begin
      st_q            <= st_d;
      ev_disconnect_o <= e_dis;
      ev_reset_o      <= e_rst;
      ev_suspend_o    <= e_sus;
      ev_resume_o     <= e_res;
      ev_host_lost_o  <= e_hl;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/usb_link_monitor.sv
module usb_link_monitor
  import usb_lm_pkg::*;
#(
  parameter int unsigned RESET_CYCLES     = 144,
  parameter int unsigned SUSPEND_CYCLES   = 144000,
  parameter int unsigned HOST_LOST_CYCLES = 196608
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       vbus_sense_i,
  input  logic [1:0] line_i,
  input  logic       sof_i,
  output logic [2:0] state_o,
  output logic       ev_disconnect_o,
  output logic       ev_reset_o,
  output logic       ev_suspend_o,
  output logic       ev_resume_o,
  output logic       ev_host_lost_o
);

  logic powered, is_se0, is_j;
  logic reset_hit, idle_hit, nosof_hit;
  logic in_active;

  assign powered   = vbus_sense_i && enable_i;
  assign in_active = (state_o == LS_ACTIVE);

  usb_lm_line_decode u_dec (
    .line_i   (line_i),
    .is_se0_o (is_se0),
    .is_j_o   (is_j)
  );

  usb_lm_hold_timer #(.LIMIT(RESET_CYCLES)) u_se0_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (powered && is_se0),
    .hit_o  (reset_hit)
  );

  usb_lm_hold_timer #(.LIMIT(SUSPEND_CYCLES)) u_idle_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (powered && is_j),
    .hit_o  (idle_hit)
  );

  usb_lm_hold_timer #(.LIMIT(HOST_LOST_CYCLES)) u_sof_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (in_active && !sof_i),
    .hit_o  (nosof_hit)
  );

  usb_lm_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .powered_i       (powered),
    .line_j_i        (is_j),
    .reset_hit_i     (reset_hit),
    .idle_hit_i      (idle_hit),
    .nosof_hit_i     (nosof_hit),
    .state_o         (state_o),
    .ev_disconnect_o (ev_disconnect_o),
    .ev_reset_o      (ev_reset_o),
    .ev_suspend_o    (ev_suspend_o),
    .ev_resume_o     (ev_resume_o),
    .ev_host_lost_o  (ev_host_lost_o)
  );

endmodule

// File: rtl/usb_link_monitor_chk.sv
module usb_link_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       vbus_sense_i,
  input logic [2:0] state_o,
  input logic       ev_disconnect_o,
  input logic       ev_reset_o,
  input logic       ev_suspend_o,
  input logic       ev_resume_o,
  input logic       ev_host_lost_o
);

  // R2
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

  // R2
  unpowered_disc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vbus_sense_i && enable_i) |=> state_o == 3'd0);

  // R2
  disc_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_disconnect_o |-> state_o == 3'd0 && $past(state_o) != 3'd0);

  // R4
  reset_to_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_reset_o |-> state_o == 3'd3);

  // R5
  suspend_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_suspend_o |-> (state_o == 3'd2 || state_o == 3'd4));

  // R6
  resume_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_resume_o |-> ($past(state_o) == 3'd2 && state_o == 3'd1) ||
                    ($past(state_o) == 3'd4 && state_o == 3'd3));

  // R6
  psusp_no_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd2 |=> state_o != 3'd3);

  // R7
  host_lost_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_host_lost_o |-> $past(state_o) == 3'd3);

  // R9
  excl_events_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_disconnect_o, ev_reset_o, ev_suspend_o, ev_resume_o}));

  // R9
  reset_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_reset_o |=> !ev_reset_o);

endmodule

bind usb_link_monitor usb_link_monitor_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .enable_i        (enable_i),
  .vbus_sense_i    (vbus_sense_i),
  .state_o         (state_o),
  .ev_disconnect_o (ev_disconnect_o),
  .ev_reset_o      (ev_reset_o),
  .ev_suspend_o    (ev_suspend_o),
  .ev_resume_o     (ev_resume_o),
  .ev_host_lost_o  (ev_host_lost_o)
);

// File: tb/usb_link_monitor_tb_top.sv
module usb_link_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RC = 8;
  localparam int SC = 40;
  localparam int HC = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       vbus = 1'b0;
  logic [1:0] line = 2'b01;
  logic       sof = 1'b0;
  logic [2:0] state;
  logic       e_dis, e_rst, e_sus, e_res, e_hl;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_link_monitor #(
    .RESET_CYCLES(RC), .SUSPEND_CYCLES(SC), .HOST_LOST_CYCLES(HC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .vbus_sense_i(vbus),
    .line_i(line), .sof_i(sof), .state_o(state),
    .ev_disconnect_o(e_dis), .ev_reset_o(e_rst), .ev_suspend_o(e_sus),
    .ev_resume_o(e_res), .ev_host_lost_o(e_hl)
  );

  // Behavioural reference model
  int m_st = 0, se0_run = 0, j_run = 0, gap = 0;
  bit x_dis, x_rst, x_sus, x_res, x_hl;

  always @(posedge clk) begin
    bit pw, r_hit, i_hit, h_hit, is_j, is_se0;
    if (!rst_n) begin
      m_st = 0; se0_run = 0; j_run = 0; gap = 0;
      x_dis = 0; x_rst = 0; x_sus = 0; x_res = 0; x_hl = 0;
    end else begin
      pw     = vbus && en;
      is_se0 = (line == 2'b00);
      is_j   = (line == 2'b01);
      r_hit  = pw && is_se0 && se0_run == RC - 1;
      i_hit  = pw && is_j && j_run == SC - 1;
      h_hit  = (m_st == 3) && !sof && gap == HC - 1;
      se0_run = (pw && is_se0) ? ((se0_run < RC) ? se0_run + 1 : se0_run) : 0;
      j_run   = (pw && is_j) ? ((j_run < SC) ? j_run + 1 : j_run) : 0;
      gap     = (m_st == 3 && !sof) ? ((gap < HC) ? gap + 1 : gap) : 0;
      x_dis = 0; x_rst = 0; x_sus = 0; x_res = 0; x_hl = 0;
      if (!pw) begin
        x_dis = (m_st != 0);
        m_st  = 0;
      end else begin
        case (m_st)
          0: m_st = 1;
          1: if (r_hit) begin m_st = 3; x_rst = 1; end
             else if (i_hit) begin m_st = 2; x_sus = 1; end
          2: if (!is_j) begin m_st = 1; x_res = 1; end
          3: begin
               x_hl = h_hit;
               if (r_hit) x_rst = 1;
               else if (i_hit) begin m_st = 4; x_sus = 1; end
             end
          4: if (!is_j) begin m_st = 3; x_res = 1; end
          default: m_st = 0;
        endcase
      end
    end
  end

  task automatic cmp(input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      cmp(state, m_st, "R2 state_o");
      cmp(e_dis, x_dis, "R2 ev_disconnect");
      cmp(e_rst, x_rst, "R4 ev_reset");
      cmp(e_sus, x_sus, "R5 ev_suspend");
      cmp(e_res, x_res, "R6 ev_resume");
      cmp(e_hl,  x_hl,  "R7 ev_host_lost");
    end
  end

  task automatic run(input logic [1:0] l, input logic s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line = l;
      sof  = s;
    end
  endtask

  task automatic chk_state(input int exp, input string tag);
    @(negedge clk);
    cmp(state, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_state(0, "R1 state in reset");
    cmp(e_dis | e_rst | e_sus | e_res | e_hl, 0, "R1 events in reset");
    rst_n = 1'b1;
    chk_state(0, "R1 state after reset");
    vbus = 1'b1;
    run(2'b01, 0, 5);
    chk_state(0, "R2 enable low holds Disconnected");
    en = 1'b1;
    run(2'b01, 0, 1);
    chk_state(1, "R3 powered");
    run(2'b01, 0, SC + 5);
    chk_state(2, "R5 powered suspend");
    run(2'b01, 0, 10);
    run(2'b10, 0, 1);
    chk_state(1, "R6 resume to Powered");
    run(2'b00, 0, RC - 3);
    run(2'b01, 0, 2);
    run(2'b00, 0, RC - 3);
    chk_state(1, "R4 interrupted SE0 no reset");
    run(2'b00, 0, RC);
    chk_state(3, "R4 reset to Active");
    run(2'b00, 0, 20);
    for (int k = 0; k < 5; k++) begin
      run(2'b10, 1, 1);
      run(2'b01, 0, 19);
    end
    chk_state(3, "R7 regular SOF keeps Active");
    run(2'b10, 0, HC + 10);
    run(2'b10, 1, 1);
    run(2'b01, 0, SC + 5);
    chk_state(4, "R5 Suspended");
    run(2'b11, 0, 1);
    chk_state(3, "R8 code 11 resumes to Active");
    run(2'b01, 0, SC + 2);
    run(2'b00, 0, RC + 4);
    chk_state(3, "R4 reset after resume");
    en = 1'b0;
    run(2'b01, 0, 2);
    chk_state(0, "R2 enable drop disconnects");
    en = 1'b1;
    run(2'b00, 0, RC + 3);
    chk_state(3, "R4 reset from fresh Powered");
    vbus = 1'b0;
    run(2'b01, 0, 3);
    chk_state(0, "R2 VBUS loss disconnects");
    run(2'b01, 0, 3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule